// File: doc/BRIEF.md
# SDRAM Column Burst Engine with Clock Suspend

This block is the column-access part of a synchronous DRAM device model. A READ or WRITE command carries a bank, a starting column and a burst-size selection. The engine then walks a burst counter through the columns of an aligned block and moves one 32-bit word per internal clock edge between the data pins and a small behavioural storage array of four banks. On a write, a per-byte mask keeps selected lanes of the stored word unchanged.

The clock-enable input `cke` is registered on every rising edge. While a burst is in progress, an edge that follows a low sample of `cke` is not an internal edge. At such an edge the burst counter, the output data and the output enable all keep their values, and command, address, data and mask inputs are ignored. No gated clock is used: the internal clock is a registered enable. When no burst is in progress, `cke` has no effect.

Top module: `sdr_burst_engine`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `dq_oe`=0 and `dq_out`=0. Any burst in progress is abandoned, and the registered clock enable is taken as high.
- R2: `cmd` encoding: 2'b00 is NOP, 2'b01 is READ, 2'b10 is WRITE, and 2'b11 acts as NOP. A WRITE stores `dq_in` at the edge of the command, as beat 0. After a READ edge, `dq_out` holds the word at the addressed column and `dq_oe` is 1.
- R3: `burst_sel` values 0, 1, 2 and 3 give 1, 2, 4 and 8 beats, one beat per internal edge. Beat i uses column (col aligned down to the burst size) + ((col + i) mod size). After the last read beat, `dq_oe` falls at the next internal edge.
- R4: A high `dqm[l]` masks byte lane l (`dq_in[8l+7:8l]`) of a write beat, and that stored byte stays unchanged. A low bit lets the byte through.
- R5: When `cke` is sampled low at a rising edge while a burst is in progress, the following edge is suppressed. `cmd`, `bank`, `col`, `dq_in` and `dqm` are ignored at that edge.
- R6: The burst counter does not advance at a suppressed edge, so no beat is lost or repeated.
- R7: At a suppressed edge, `dq_out` and `dq_oe` keep their values.
- R8: After `cke` is sampled high, the next rising edge is an internal edge again.
- R9: With no burst in progress, a command is accepted at every rising edge, whatever `cke` was.
- R10: A READ or WRITE accepted during a burst ends the old burst and starts the new one. The old burst's remaining beats are not performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable, registered every edge |
| cmd | input | 2 | Command code (NOP, READ, WRITE) |
| burst_sel | input | 2 | Burst size select, taken with the command |
| bank | input | 2 | Bank, taken with the command |
| col | input | 4 | Starting column, taken with the command |
| dq_in | input | 32 | Write data |
| dqm | input | 4 | Byte-lane write mask, 1 = masked |
| dq_out | output | 32 | Read data |
| dq_oe | output | 1 | Read data valid and driven |

## Verification
Two functions can fall on the same edge. The first pair is command decode and clock suspension: the bench presents a READ, or a WRITE with marked data, on the very cycle whose internal edge is suppressed. It judges the result by `dq_oe` and `dq_out` on the following cycles and by reading the targeted column back afterwards. The second pair is burst stepping and a new command: the bench issues a READ two beats into a write burst. It confirms that the read data appears at once and that the abandoned columns keep their earlier contents.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

    localparam int unsigned DEF_DATA_W = 32;
    localparam int unsigned DEF_BANKS  = 4;
    localparam int unsigned DEF_COL_W  = 4;
    localparam int unsigned MAX_BEATS  = 8;
    localparam int unsigned BEAT_W     = $clog2(MAX_BEATS) + 1;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_RSVD  = 2'b11
    } sdr_cmd_e;

    typedef struct packed {
        logic go;   // column command present
        logic wr;   // direction of that command
    } cmd_dec_t;

    function automatic cmd_dec_t decode_cmd(input logic [1:0] code);
        cmd_dec_t d;
        d.go = (code == CMD_READ) || (code == CMD_WRITE);
        d.wr = (code == CMD_WRITE);
        return d;
    endfunction

    function automatic logic [BEAT_W-1:0] beats_of(input logic [1:0] sel);
        return BEAT_W'(1) << sel;
    endfunction

endpackage

// File: rtl/sdr_cke_gate.sv
module sdr_cke_gate (
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  logic busy,
    output logic ie
);
    logic cke_q;

    always_ff @(posedge clk) begin
        if (rst) cke_q <= 1'b1;
        else     cke_q <= cke;
    end

    // Suspension only bites while a burst is running (R9)
    assign ie = cke_q | ~busy;

    a_r8_resume: assert property (@(posedge clk) disable iff (rst)
        cke |=> ie);

endmodule

// File: rtl/sdr_burst_ctr.sv
module sdr_burst_ctr
    import sdr_burst_pkg::*;
#(
    parameter int unsigned COL_W = DEF_COL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ie,
    input  logic             start,
    input  logic [1:0]       sel,
    input  logic [COL_W-1:0] col_in,
    output logic             busy,
    output logic [COL_W-1:0] col_addr
);
    logic [COL_W-1:0]  start_q;
    logic [COL_W-1:0]  wrap_mask;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] len_q;
    logic [BEAT_W-1:0] len_new;

    assign len_new   = beats_of(sel);
    assign wrap_mask = COL_W'(len_q - BEAT_W'(1));
    assign col_addr  = (start_q & ~wrap_mask)
                     | ((start_q + COL_W'(beat_q)) & wrap_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            beat_q  <= '0;
            len_q   <= BEAT_W'(1);
            start_q <= '0;
        end else if (ie) begin
            if (start) begin
                start_q <= col_in;
                len_q   <= len_new;
                beat_q  <= BEAT_W'(1);
                busy    <= (len_new != BEAT_W'(1));
            end else if (busy) begin
                beat_q <= beat_q + BEAT_W'(1);
                if (beat_q == len_q - BEAT_W'(1)) busy <= 1'b0;
            end
        end
    end

    a_r6_beat_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && !ie) |=> ($stable(beat_q) && $stable(start_q) && busy));

    a_r3_beat_in_range: assert property (@(posedge clk) disable iff (rst)
        busy |-> (beat_q != '0 && beat_q < len_q));

endmodule

// File: rtl/sdr_bank_array.sv
module sdr_bank_array #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BANKS  = 4,
    parameter int unsigned COL_W  = 4,
    localparam int unsigned BANK_W = $clog2(BANKS),
    localparam int unsigned LANES  = DATA_W / 8,
    localparam int unsigned DEPTH  = BANKS << COL_W,
    localparam int unsigned AW     = BANK_W + COL_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [BANK_W-1:0] bank_a,
    input  logic [COL_W-1:0]  col_a,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  wmask,
    output logic [DATA_W-1:0] rdata
);
    logic [AW-1:0] idx;
    assign idx = {bank_a, col_a};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && !wmask[l]) lane_mem[idx] <= wdata[l*8 +: 8];
        end

        assign rdata[l*8 +: 8] = lane_mem[idx];
    end

endmodule

// File: rtl/sdr_burst_engine.sv
module sdr_burst_engine
    import sdr_burst_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned BANKS  = DEF_BANKS,
    parameter int unsigned COL_W  = DEF_COL_W,
    localparam int unsigned BANK_W = $clog2(BANKS),
    localparam int unsigned LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic [1:0]        cmd,
    input  logic [1:0]        burst_sel,
    input  logic [BANK_W-1:0] bank,
    input  logic [COL_W-1:0]  col,
    input  logic [DATA_W-1:0] dq_in,
    input  logic [LANES-1:0]  dqm,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    logic              ie;
    logic              busy;
    logic              go;
    logic              wr_q;
    logic              cur_wr;
    logic              beat_now;
    logic              we;
    logic [BANK_W-1:0] bank_q;
    logic [BANK_W-1:0] cur_bank;
    logic [COL_W-1:0]  burst_col;
    logic [COL_W-1:0]  cur_col;
    logic [DATA_W-1:0] rdata;
    cmd_dec_t          dec;

    assign dec      = decode_cmd(cmd);
    assign go       = ie & dec.go;
    assign beat_now = go | busy;
    assign cur_wr   = go ? dec.wr : wr_q;
    assign cur_bank = go ? bank   : bank_q;
    assign cur_col  = go ? col    : burst_col;
    assign we       = ie & beat_now & cur_wr;

    sdr_cke_gate u_gate (
        .clk  (clk),
        .rst  (rst),
        .cke  (cke),
        .busy (busy),
        .ie   (ie)
    );

    sdr_burst_ctr #(.COL_W(COL_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .ie       (ie),
        .start    (go),
        .sel      (burst_sel),
        .col_in   (col),
        .busy     (busy),
        .col_addr (burst_col)
    );

    sdr_bank_array #(.DATA_W(DATA_W), .BANKS(BANKS), .COL_W(COL_W)) u_arr (
        .clk    (clk),
        .we     (we),
        .bank_a (cur_bank),
        .col_a  (cur_col),
        .wdata  (dq_in),
        .wmask  (dqm),
        .rdata  (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dq_out <= '0;
            dq_oe  <= 1'b0;
            wr_q   <= 1'b0;
            bank_q <= '0;
        end else if (ie) begin
            if (go) begin
                wr_q   <= dec.wr;
                bank_q <= bank;
            end
            if (beat_now && !cur_wr) begin
                dq_out <= rdata;
                dq_oe  <= 1'b1;
            end else begin
                dq_oe  <= 1'b0;
            end
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!dq_oe && dq_out == '0));

    a_r2_read_drives: assert property (@(posedge clk) disable iff (rst)
        (go && !dec.wr) |=> dq_oe);

    a_r7_suspend_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !ie) |=> ($stable(dq_out) && $stable(dq_oe)));

endmodule

// File: tb/test_sdr_burst_engine.sv
module test_sdr_burst_engine;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] C_NOP = 2'b00, C_RD = 2'b01, C_WR = 2'b10, C_RSV = 2'b11;

    // table entry: {burst_sel[1:0], bank[1:0], col[3:0], base[31:0]}
    localparam logic [39:0] VECS [6] = '{
        {2'd0, 2'd0, 4'd5,  32'hA5A5_0001},
        {2'd1, 2'd1, 4'd3,  32'h1234_5678},
        {2'd2, 2'd2, 4'd6,  32'hC0DE_0100},
        {2'd3, 2'd3, 4'd13, 32'h0F0F_3000},
        {2'd3, 2'd0, 4'd8,  32'h7777_0000},
        {2'd2, 2'd1, 4'd0,  32'h5A5A_9000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b1;
    logic [1:0]  cmd = C_NOP;
    logic [1:0]  burst_sel = 2'd0;
    logic [1:0]  bank = 2'd0;
    logic [3:0]  col = 4'd0;
    logic [31:0] dq_in = '0;
    logic [3:0]  dqm = '0;
    logic [31:0] dq_out;
    logic        dq_oe;

    logic [31:0] ref_mem [64];
    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdr_burst_engine i_sdr_burst_engine (
        .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .burst_sel(burst_sel),
        .bank(bank), .col(col), .dq_in(dq_in), .dqm(dqm),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    // one clock: drive at negedge, return at the next negedge
    task automatic cyc(input logic [1:0] c, input logic [1:0] bs, input logic [1:0] b,
                       input logic [3:0] cl, input logic [31:0] d, input logic [3:0] m,
                       input logic k);
        cmd = c; burst_sel = bs; bank = b; col = cl; dq_in = d; dqm = m; cke = k;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [3:0] wcol(input logic [3:0] c, input logic [1:0] bs, input int i);
        int len = 1 << bs;
        return 4'(((int'(c) / len) * len) + ((int'(c) + i) % len));
    endfunction

    function automatic void ref_write(input logic [1:0] b, input logic [3:0] c,
                                      input logic [31:0] d, input logic [3:0] m);
        for (int l = 0; l < 4; l++)
            if (!m[l]) ref_mem[{b, c}][l*8 +: 8] = d[l*8 +: 8];
    endfunction

    task automatic wr_burst(input logic [1:0] bs, input logic [1:0] b, input logic [3:0] cl,
                            input logic [31:0] base, input logic [3:0] m);
        for (int i = 0; i < (1 << bs); i++) begin
            logic [31:0] d = base ^ (32'h1111_1111 * i);
            cyc(i == 0 ? C_WR : C_NOP, bs, b, cl, d, m, 1'b1);
            ref_write(b, wcol(cl, bs, i), d, m);
        end
    endtask

    task automatic rd_burst(input string rq, input logic [1:0] bs, input logic [1:0] b,
                            input logic [3:0] cl);
        for (int i = 0; i < (1 << bs); i++) begin
            cyc(i == 0 ? C_RD : C_NOP, bs, b, cl, 32'h0, 4'h0, 1'b1);
            chk(rq, {31'b0, dq_oe}, 32'd1);
            chk(rq, dq_out, ref_mem[{b, wcol(cl, bs, i)}]);
        end
        cyc(C_NOP, 2'd0, 2'd0, 4'd0, 32'h0, 4'h0, 1'b1);
        chk("R3 oe drop", {31'b0, dq_oe}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        repeat (3) cyc(C_NOP, 2'd0, 2'd0, 4'd0, 32'h0, 4'h0, 1'b1);
        chk("R1 oe", {31'b0, dq_oe}, 32'd0);
        chk("R1 dq", dq_out, 32'd0);
        rst = 1'b0;

        // table of write-then-read bursts, all sizes and wrap positions (R2, R3)
        for (int v = 0; v < 6; v++) begin
            wr_burst(VECS[v][39:38], VECS[v][37:36], VECS[v][35:32], VECS[v][31:0], 4'h0);
            rd_burst("R3", VECS[v][39:38], VECS[v][37:36], VECS[v][35:32]);
        end

        // R4: byte-lane masks, partial and full
        wr_burst(2'd2, 2'd2, 4'd4, 32'hDEAD_BEEF, 4'b0101);
        rd_burst("R4", 2'd2, 2'd2, 4'd4);
        wr_burst(2'd1, 2'd3, 4'd10, 32'hFFFF_FFFF, 4'b1111);
        rd_burst("R4", 2'd1, 2'd3, 4'd10);

        // R5/R6: suspension during a write burst, READ offered at the suppressed edge
        cyc(C_WR,  2'd2, 2'd1, 4'd0, 32'hAAAA_0000, 4'h0, 1'b1); ref_write(2'd1, 4'd0, 32'hAAAA_0000, 4'h0);
        cyc(C_NOP, 2'd2, 2'd1, 4'd0, 32'hAAAA_0001, 4'h0, 1'b0); ref_write(2'd1, 4'd1, 32'hAAAA_0001, 4'h0);
        cyc(C_RD,  2'd2, 2'd3, 4'd9, 32'hBAD0_BAD0, 4'h0, 1'b1);
        chk("R5 read ignored", {31'b0, dq_oe}, 32'd0);
        cyc(C_NOP, 2'd2, 2'd1, 4'd0, 32'hAAAA_0002, 4'h0, 1'b1); ref_write(2'd1, 4'd2, 32'hAAAA_0002, 4'h0);
        cyc(C_NOP, 2'd2, 2'd1, 4'd0, 32'hAAAA_0003, 4'h0, 1'b1); ref_write(2'd1, 4'd3, 32'hAAAA_0003, 4'h0);
        cyc(C_NOP, 2'd0, 2'd0, 4'd0, 32'h0, 4'h0, 1'b1);
        rd_burst("R6", 2'd2, 2'd1, 4'd0);

        // R7/R8: two suppressed edges during a read burst, WRITE offered while suspended
        cyc(C_RD,  2'd2, 2'd3, 4'd9, 32'h0, 4'h0, 1'b1);
        chk("R2 beat0", dq_out, ref_mem[{2'd3, 4'd9}]);
        cyc(C_NOP, 2'd2, 2'd3, 4'd9, 32'h0, 4'h0, 1'b0);
        chk("R7 beat1", dq_out, ref_mem[{2'd3, 4'd10}]);
        cyc(C_WR,  2'd0, 2'd0, 4'd5, 32'hFFFF_FFFF, 4'h0, 1'b0);
        chk("R7 hold1", dq_out, ref_mem[{2'd3, 4'd10}]);
        chk("R7 oe1", {31'b0, dq_oe}, 32'd1);
        cyc(C_NOP, 2'd2, 2'd3, 4'd9, 32'h0, 4'h0, 1'b1);
        chk("R7 hold2", dq_out, ref_mem[{2'd3, 4'd10}]);
        cyc(C_NOP, 2'd2, 2'd3, 4'd9, 32'h0, 4'h0, 1'b1);
        chk("R8 beat2", dq_out, ref_mem[{2'd3, 4'd11}]);
        cyc(C_NOP, 2'd2, 2'd3, 4'd9, 32'h0, 4'h0, 1'b1);
        chk("R6 beat3 wrap", dq_out, ref_mem[{2'd3, 4'd8}]);
        cyc(C_NOP, 2'd0, 2'd0, 4'd0, 32'h0, 4'h0, 1'b1);
        chk("R3 oe drop", {31'b0, dq_oe}, 32'd0);
        rd_burst("R5 write ignored", 2'd0, 2'd0, 4'd5);

        // R9: with no burst, low cke does not block commands
        cyc(C_NOP, 2'd0, 2'd0, 4'd0, 32'h0, 4'h0, 1'b0);
        cyc(C_RD,  2'd0, 2'd2, 4'd4, 32'h0, 4'h0, 1'b0);
        chk("R9 read oe", {31'b0, dq_oe}, 32'd1);
        chk("R9 read dq", dq_out, ref_mem[{2'd2, 4'd4}]);
        cyc(C_WR,  2'd0, 2'd0, 4'd7, 32'h600D_F00D, 4'h0, 1'b0); ref_write(2'd0, 4'd7, 32'h600D_F00D, 4'h0);
        cyc(C_NOP, 2'd0, 2'd0, 4'd0, 32'h0, 4'h0, 1'b1);
        rd_burst("R9", 2'd0, 2'd0, 4'd7);

        // R2: reserved code acts as NOP
        cyc(C_RSV, 2'd3, 2'd0, 4'd7, 32'h0, 4'h0, 1'b1);
        chk("R2 reserved", {31'b0, dq_oe}, 32'd0);

        // R10: READ cuts a write burst short
        cyc(C_WR,  2'd3, 2'd0, 4'd8, 32'hCAFE_0008, 4'h0, 1'b1); ref_write(2'd0, 4'd8, 32'hCAFE_0008, 4'h0);
        cyc(C_NOP, 2'd3, 2'd0, 4'd8, 32'hCAFE_0009, 4'h0, 1'b1); ref_write(2'd0, 4'd9, 32'hCAFE_0009, 4'h0);
        cyc(C_RD,  2'd0, 2'd2, 4'd4, 32'hCAFE_000A, 4'h0, 1'b1);
        chk("R10 read now", dq_out, ref_mem[{2'd2, 4'd4}]);
        cyc(C_NOP, 2'd0, 2'd0, 4'd0, 32'hCAFE_000B, 4'h0, 1'b1);
        chk("R10 oe drop", {31'b0, dq_oe}, 32'd0);
        rd_burst("R10", 2'd3, 2'd0, 4'd8);

        // R1: reset in mid read burst
        cyc(C_RD,  2'd3, 2'd3, 4'd8, 32'h0, 4'h0, 1'b1);
        rst = 1'b1;
        cyc(C_NOP, 2'd0, 2'd0, 4'd0, 32'h0, 4'h0, 1'b1);
        rst = 1'b0;
        chk("R1 mid oe", {31'b0, dq_oe}, 32'd0);
        chk("R1 mid dq", dq_out, 32'd0);
        cyc(C_NOP, 2'd0, 2'd0, 4'd0, 32'h0, 4'h0, 1'b1);
        chk("R1 abandoned", {31'b0, dq_oe}, 32'd0);

        finish_run();
    end

endmodule